// File: doc/BRIEF.md
# SDRAM Mode-Register Initialization Sequencer

This block drives the command bus of a double-data-rate SDRAM while its mode registers are set up and its DLL is brought up. That happens after power-on, or when the memory returns from a debug state with the DLL turned off. A start request launches a fixed sequence. First comes a load of the extended mode register with the DLL-enable bit forced on. Next comes a load of the base mode register with the DLL-reset bit forced on. Each load waits until the banks report idle. A minimum spacing follows each load. The block then counts a lock period with clock-enable held high.

When the lock count expires, the block drops its busy flag and raises a flag that allows the memory controller to issue reads. At every other time the block drives a no-operation command. Software-chosen register contents come in on two configuration buses. They are passed to the address pins unchanged, except for the one DLL bit that the sequence itself owns.

Top module: `mrs_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block drives NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), cke=0, busy=0 and rd_ok=0.
- R2: A start sampled while the block is idle or done makes busy and cke high from the next cycle. cke then stays high until reset. A start sampled while busy has no effect on the commands issued or on rd_ok timing.
- R3: The first command of a sequence is a register load (cs_n, ras_n, cas_n and we_n all 0) with ba=2'b01 and addr equal to ext_cfg with bit 0 forced to 0 (DLL enable).
- R4: The second register load uses ba=2'b00 and addr equal to base_cfg with bit 8 forced to 1 (DLL reset).
- R5: The second load is issued no earlier than TMRD cycles after the first. With banks idle it is issued exactly TMRD cycles later (TMRD >= 2).
- R6: A register load is issued only in the cycle after banks_idle was sampled high. While banks_idle is low, the due load is held and NOP is driven.
- R7: Every non-load cycle carries NOP, and each sequence issues exactly two loads.
- R8: rd_ok rises exactly LOCK_CYCLES cycles after the base-register load, in the same cycle that busy falls, and rd_ok is only ever high while cke is high.
- R9: rd_ok clears on reset, and in the cycle after a new start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the initialization sequence |
| banks_idle | input | 1 | High when all banks are precharged and no burst is active |
| ext_cfg | input | AW | Extended mode register contents |
| base_cfg | input | AW | Base mode register contents |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ba | output | 2 | Bank address, selects the register being loaded |
| addr | output | AW | Address bus carrying register contents |
| busy | output | 1 | Sequence in progress |
| rd_ok | output | 1 | Reads permitted |

## Verification
The hardest case to reach is a second register load that is held off by busy banks after its spacing interval has already run out. There, the load time depends on the later of the two constraints and not on TMRD alone. The stimulus lowers banks_idle exactly in the cycle of the first load and raises it again after a chosen delay. Delays both shorter and longer than TMRD are tried, so each constraint in turn sets the issue cycle. A start pulse placed in the middle of the lock period checks that the count is not restarted.

// File: rtl/mrs_init_seq.sv
module mrs_init_seq #(
  parameter int TMRD        = 2,
  parameter int LOCK_CYCLES = 200,
  parameter int AW          = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          banks_idle,
  input  logic [AW-1:0] ext_cfg,
  input  logic [AW-1:0] base_cfg,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          cke,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          rd_ok
);

  localparam int GW  = $clog2(TMRD + 1);
  localparam int LW  = $clog2(LOCK_CYCLES + 1);
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_LMR = 4'b0000;
  localparam logic [AW-1:0] DLL_EN_BIT  = AW'(1);
  localparam logic [AW-1:0] DLL_RST_BIT = AW'(1) << 8;

  typedef enum logic [2:0] {ST_IDLE, ST_EXT, ST_GAP, ST_BASE, ST_LOCK, ST_DONE} st_t;

  st_t           st;
  logic [3:0]    cmd;
  logic [GW-1:0] gap;
  logic [LW-1:0] lock;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign busy = (st != ST_IDLE) && (st != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cmd   <= CMD_NOP;
      ba    <= '0;
      addr  <= '0;
      cke   <= 1'b0;
      rd_ok <= 1'b0;
      gap   <= '0;
      lock  <= '0;
    end else begin
      cmd <= CMD_NOP;
      case (st)
        ST_IDLE, ST_DONE: if (start) begin
          st    <= ST_EXT;
          cke   <= 1'b1;
          rd_ok <= 1'b0;
        end
        ST_EXT: if (banks_idle) begin
          cmd  <= CMD_LMR;
          ba   <= 2'b01;
          addr <= ext_cfg & ~DLL_EN_BIT;
          gap  <= GW'(TMRD - 1);
          st   <= ST_GAP;
        end
        ST_GAP: begin
          if (gap <= GW'(1)) st <= ST_BASE;
          else               gap <= gap - 1'b1;
        end
        ST_BASE: if (banks_idle) begin
          cmd  <= CMD_LMR;
          ba   <= 2'b00;
          addr <= base_cfg | DLL_RST_BIT;
          lock <= LW'(LOCK_CYCLES);
          st   <= ST_LOCK;
        end
        ST_LOCK: begin
          if (lock <= LW'(1)) begin
            st    <= ST_DONE;
            rd_ok <= 1'b1;
          end else begin
            lock <= lock - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  localparam int SAT = LOCK_CYCLES + TMRD;
  localparam int SW  = $clog2(SAT + 1);
  logic          lmr_now;
  logic [SW-1:0] since;
  assign lmr_now = (cmd == CMD_LMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since <= SW'(SAT);
    else if (lmr_now)           since <= SW'(1);
    else if (since < SW'(SAT))  since <= since + 1'b1;
  end

  AST_LMR_BANKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_now |-> $past(banks_idle)); // R6
  AST_LMR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_now |-> since >= SW'(TMRD)); // R5
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && (({ras_n, cas_n, we_n} == 3'b111) || ({ras_n, cas_n, we_n} == 3'b000))); // R7
  AST_RDOK_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> since == SW'(LOCK_CYCLES)); // R8
  AST_RDOK_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> cke); // R8
  AST_RDOK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ok && busy)); // R8
  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> 1'b0); // R2

endmodule

// File: tb/test_mrs_init_seq.sv
module test_mrs_init_seq;
  localparam int TMRD = 3;
  localparam int LOCK = 24;

  logic clk = 0, rst_n = 0, start = 0, banks_idle = 1;
  logic [12:0] ext_cfg = '0, base_cfg = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, busy, rd_ok;
  logic [1:0] ba;
  logic [12:0] addr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mrs_init_seq #(.TMRD(TMRD), .LOCK_CYCLES(LOCK), .AW(13)) i_mrs_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .banks_idle(banks_idle),
    .ext_cfg(ext_cfg), .base_cfg(base_cfg), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
    .busy(busy), .rd_ok(rd_ok));

  // [31:19] ext, [18:6] base, [5:3] hold before first load, [2:0] hold before second load
  localparam logic [31:0] VEC [5] = '{
    {13'h1FFF, 13'h0000, 3'd0, 3'd0},
    {13'h0002, 13'h0062, 3'd3, 3'd0},
    {13'h0AAB, 13'h1555, 3'd0, 3'd5},
    {13'h0000, 13'h1FFF, 3'd6, 3'd1},
    {13'h1235, 13'h0ABC, 3'd2, 3'd2}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, {tag, " R1 command NOP"}, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(cke == 0 && busy == 0 && rd_ok == 0, {tag, " R1 cke/busy/rd_ok low"}, {cke, busy, rd_ok}, 0);
  endtask

  task automatic run_seq(input logic [12:0] e, input logic [12:0] b, input int h1, input int h2,
                         input bit poke, input bit check_clear);
    int t1 = -1, t2 = -1, t3 = -1, nl = 0, bad_cmd = 0, e1, e2, e3;
    logic [1:0] ba1 = '0, ba2 = '0;
    logic [12:0] a1 = '0, a2 = '0;
    bit busy_pre = 0, cke_drop = 0, busy_at_t3 = 1;
    ext_cfg = e; base_cfg = b;
    banks_idle = (h1 == 0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && cke, "R2 busy and cke after start", {busy, cke}, 3);
    if (check_clear) chk(rd_ok == 0, "R9 rd_ok cleared by new start", rd_ok, 0);
    for (int n = 1; n < 400; n++) begin
      if (!cke) cke_drop = 1;
      if (!cs_n && !ras_n && !cas_n && !we_n) begin
        nl++;
        if (nl == 1) begin t1 = n; ba1 = ba; a1 = addr; if (h2 > 0) banks_idle = 0; end
        else if (nl == 2) begin t2 = n; ba2 = ba; a2 = addr; end
      end else if (!({cs_n, ras_n, cas_n, we_n} == 4'b0111)) bad_cmd++;
      if (rd_ok && t3 < 0) begin t3 = n; busy_at_t3 = busy; end
      if (t2 > 0 && t3 < 0 && n == t2 + LOCK - 1) busy_pre = busy;
      if (h1 >= 1 && n == h1) banks_idle = 1;
      if (h2 > 0 && t1 > 0 && n == t1 + h2) banks_idle = 1;
      if (poke && t2 > 0 && n == t2 + 4) start = 1;
      if (poke && t2 > 0 && n == t2 + 5) start = 0;
      if (t3 > 0 && n >= t3 + 2) break;
      @(negedge clk);
    end
    banks_idle = 1;
    e1 = ((h1 > 1) ? h1 : 1) + 1;
    e2 = (h2 > 0 && h2 + 1 > TMRD) ? e1 + h2 + 1 : e1 + TMRD;
    e3 = e2 + LOCK;
    chk(t1 == e1, "R6 first load cycle", t1, e1);
    chk(ba1 == 2'b01, "R3 extended select", ba1, 1);
    chk(a1 == (e & 13'h1FFE), "R3 extended contents", a1, e & 13'h1FFE);
    chk(t2 == e2, "R5 R6 second load cycle", t2, e2);
    chk(ba2 == 2'b00, "R4 base select", ba2, 0);
    chk(a2 == (b | 13'h0100), "R4 base contents", a2, b | 13'h0100);
    chk(t3 == e3, "R8 rd_ok rise cycle", t3, e3);
    chk(busy_pre == 1 && busy_at_t3 == 0, "R8 busy falls with rd_ok", {busy_pre, busy_at_t3}, 2);
    chk(nl == 2 && bad_cmd == 0, "R7 two loads, NOP otherwise", {nl, bad_cmd}, 2 << 8);
    chk(!cke_drop, "R2 cke held high", cke_drop, 0);
  endtask

  initial begin
    #(20 * 50000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1;
    @(negedge clk);
    chk_reset_state("after release");
    for (int v = 0; v < 5; v++)
      run_seq(VEC[v][31:19], VEC[v][18:6], int'(VEC[v][5:3]), int'(VEC[v][2:0]), 1'b0, v > 0);
    run_seq(13'h0777, 13'h0033, 0, 0, 1'b1, 1'b1);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk_reset_state("mid-sequence reset R9");
    rst_n = 1;
    @(negedge clk);
    chk_reset_state("after second release");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule